// File: doc/BRIEF.md
# Triggered One-Pulse Phase-Shift PWM Generator

This block produces two PWM waveforms whose relative phase is set by a single compare value. A free-running master counter defines the switching period and drives a reference PWM output. An internal phase compare channel on the same counter goes high with the reference at the start of every period. Its falling edge, where the master count equals the phase value, becomes a one-cycle trigger.

That trigger starts a slave counter in hardware. The slave runs in one-pulse mode: it leaves its idle state, produces one high pulse of programmed width on the shifted output, and then returns to idle by itself to wait for the next trigger. No control write restarts the slave. Period, reference duty, phase compare and pulse width can all be changed at any time. The master takes new values only at a period boundary, and the slave keeps the width it captured when it started.

The shifted output rises `phase + 1` cycles after the reference. The extra cycle is the slave's start latency. It can be cancelled by programming the phase value one count lower.

Top module: `psh_pwm_top`

## Requirements
- R1: While reset is low, and in the first output sample after reset is released, the reference, shifted and trigger outputs are all 0.
- R2: In steady state, any window of P consecutive cycles contains exactly min(duty, P) cycles with the reference output high. Here P is the effective period. Duty 0 keeps the reference low, and duty of at least P keeps it high.
- R3: The master counter counts 0 to P-1 and wraps. With 1 ≤ duty < P, consecutive rising edges of the reference are exactly P cycles apart.
- R4: The trigger output is high for exactly one cycle per period, at master count equal to the phase value, when 1 ≤ phase ≤ P-1. For phase 0, or phase ≥ P, it stays low for the whole period.
- R5: When the slave is idle, the shifted output rises exactly phase+1 cycles after the reference rises in the same period.
- R6: Each started slave pulse keeps the shifted output high for exactly width cycles. A trigger that arrives while the latched width is 0 starts no pulse.
- R7: A trigger that arrives while the slave pulse is running is ignored. The pulse is neither restarted nor lengthened, so with width 12, period 8 and phase 2 the output repeats 12 cycles high then 4 cycles low.
- R8: Values written to period, duty and phase take effect only at the start of the next master period. A period in progress finishes with the values it began with.
- R9: A period value below 2 is treated as 2.
- R10: The slave captures the width when it starts. Changing the width while a pulse runs does not alter that pulse, and the new width applies to the next pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_period | input | W | Master period in clock cycles (values below 2 act as 2) |
| cfg_duty | input | W | Reference high time in cycles from the period start |
| cfg_phase | input | W | Master count at which the phase channel falls and the trigger fires |
| cfg_width | input | W | Slave pulse length in cycles (0 = no pulse) |
| ref_pwm_o | output | 1 | Reference PWM, registered |
| shift_pwm_o | output | 1 | Phase-shifted PWM, registered |
| trig_o | output | 1 | One-cycle trigger pulse, registered |

## Verification
The bench builds the block with W = 5, so every period, duty, phase and width value used stays under 32. This lets one run sweep every phase value from 0 to one past a 12-cycle period, every width from 0 to 6, every duty from 0 to past a 10-cycle period, and every period from 0 to 14, including the values that clamp to 2. The small counters also make the slave pulse longer than the master period, which is what exposes ignored retriggers and a width change made mid-pulse.

// File: rtl/psh_pkg.sv
// Package: shared constants and types for the phase-shift PWM generator.
// Assumes: nothing beyond IEEE 1800-2017 semantics.
package psh_pkg;

    // Smallest master period the counter can run with.
    localparam int unsigned PSH_MIN_PERIOD = 2;

    // Slave one-pulse counter state.
    typedef enum logic {
        SLV_IDLE = 1'b0,
        SLV_RUN  = 1'b1
    } psh_slv_state_e;

endpackage

// File: rtl/psh_cfg_shadow.sv
// Module: psh_cfg_shadow
// Holds the active copy of the runtime settings. It loads all four settings
// together on the load strobe the master raises at a period boundary.
// Assumes: load is a single-cycle strobe. The settings can change freely between loads.
module psh_cfg_shadow
    import psh_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] cfg_period,
    input  logic [W-1:0] cfg_duty,
    input  logic [W-1:0] cfg_phase,
    input  logic [W-1:0] cfg_width,
    output logic [W-1:0] act_per,
    output logic [W-1:0] act_duty,
    output logic [W-1:0] act_phase,
    output logic [W-1:0] act_width
);

    localparam logic [W-1:0] MIN_PER = W'(PSH_MIN_PERIOD);

    logic [W-1:0] per_clamped;

    // Raise short periods to the minimum the counter supports.
    always_comb begin
        per_clamped = (cfg_period < MIN_PER) ? MIN_PER : cfg_period;
    end

    // Capture all settings together at the period boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_per   <= MIN_PER;
            act_duty  <= '0;
            act_phase <= '0;
            act_width <= '0;
        end else if (load) begin
            act_per   <= per_clamped;
            act_duty  <= cfg_duty;
            act_phase <= cfg_phase;
            act_width <= cfg_width;
        end
    end

endmodule

// File: rtl/psh_master_ctr.sv
// Module: psh_master_ctr
// Free-running period counter. It drives the reference compare, the internal
// phase channel and its falling-edge trigger. After reset it spends one idle
// cycle loading the settings, then runs 0..act_per-1 without stopping.
// Assumes: act_per >= 2 (guaranteed by psh_cfg_shadow).
module psh_master_ctr #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] act_per,
    input  logic [W-1:0] act_duty,
    input  logic [W-1:0] act_phase,
    output logic         load,
    output logic         ref_c,
    output logic         phase_c,
    output logic         trig_c,
    output logic [W-1:0] m_cnt
);

    logic first_q;
    logic wrap;

    // Flag the single loading cycle that follows reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
        end else begin
            first_q <= 1'b0;
        end
    end

    // Detect the last count of the period and request a load there.
    always_comb begin
        wrap = !first_q && (m_cnt == act_per - 1'b1);
        load = first_q || wrap;
    end

    // Count through the period and restart at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= '0;
        end else if (first_q || wrap) begin
            m_cnt <= '0;
        end else begin
            m_cnt <= m_cnt + 1'b1;
        end
    end

    // Compare outputs: reference, phase channel and the phase channel's falling edge.
    always_comb begin
        ref_c   = !first_q && (m_cnt < act_duty);
        phase_c = !first_q && (m_cnt < act_phase);
        trig_c  = !first_q && (act_phase != '0) && (m_cnt == act_phase);
    end

endmodule

// File: rtl/psh_slave_ctr.sv
// Module: psh_slave_ctr
// One-pulse slave counter. It rests with the count at 0. A trigger starts it
// with count 1 and the width captured at that moment. It stays high while it
// counts up to that width, then clears itself and the count. Triggers that
// arrive while it runs are ignored.
// Assumes: trig is a single-cycle pulse from the master.
module psh_slave_ctr
    import psh_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         trig,
    input  logic [W-1:0] act_width,
    output logic         s_run,
    output logic [W-1:0] s_cnt,
    output logic [W-1:0] s_width
);

    psh_slv_state_e state_q;
    logic           start;
    logic           finish;

    // Decide whether this cycle starts or ends a pulse.
    always_comb begin
        start  = (state_q == SLV_IDLE) && trig && (act_width != '0);
        finish = (state_q == SLV_RUN) && (s_cnt == s_width);
        s_run  = (state_q == SLV_RUN);
    end

    // Run/idle sequencing together with the pulse counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SLV_IDLE;
            s_cnt   <= '0;
            s_width <= '0;
        end else if (start) begin
            state_q <= SLV_RUN;
            s_cnt   <= W'(1);
            s_width <= act_width;
        end else if (finish) begin
            state_q <= SLV_IDLE;
            s_cnt   <= '0;
        end else if (state_q == SLV_RUN) begin
            s_cnt   <= s_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/psh_pwm_top.sv
// Module: psh_pwm_top
// Phase-shifted PWM pair. The master counter makes the reference and fires a
// trigger at the phase compare. The trigger starts a one-pulse slave whose
// output is the shifted PWM. All three outputs are registered so they leave
// the block free of glitches and with equal latency.
// Assumes: synchronous active-low reset. The settings may change at any time.
module psh_pwm_top #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cfg_period,
    input  logic [W-1:0] cfg_duty,
    input  logic [W-1:0] cfg_phase,
    input  logic [W-1:0] cfg_width,
    output logic         ref_pwm_o,
    output logic         shift_pwm_o,
    output logic         trig_o
);

    logic         load;
    logic [W-1:0] act_per;
    logic [W-1:0] act_duty;
    logic [W-1:0] act_phase;
    logic [W-1:0] act_width;
    logic         ref_c;
    logic         phase_c;
    logic         trig_c;
    logic [W-1:0] m_cnt;
    logic         slv_run;
    logic [W-1:0] slv_cnt;
    logic [W-1:0] slv_width;

    psh_cfg_shadow #(.W(W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .cfg_period (cfg_period),
        .cfg_duty   (cfg_duty),
        .cfg_phase  (cfg_phase),
        .cfg_width  (cfg_width),
        .act_per    (act_per),
        .act_duty   (act_duty),
        .act_phase  (act_phase),
        .act_width  (act_width)
    );

    psh_master_ctr #(.W(W)) u_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_per    (act_per),
        .act_duty   (act_duty),
        .act_phase  (act_phase),
        .load       (load),
        .ref_c      (ref_c),
        .phase_c    (phase_c),
        .trig_c     (trig_c),
        .m_cnt      (m_cnt)
    );

    psh_slave_ctr #(.W(W)) u_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig_c),
        .act_width  (act_width),
        .s_run      (slv_run),
        .s_cnt      (slv_cnt),
        .s_width    (slv_width)
    );

    // Output register stage for all three waveforms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_pwm_o   <= 1'b0;
            shift_pwm_o <= 1'b0;
            trig_o      <= 1'b0;
        end else begin
            ref_pwm_o   <= ref_c;
            shift_pwm_o <= slv_run;
            trig_o      <= trig_c;
        end
    end

endmodule

// File: rtl/psh_pwm_chk.sv
// Module: psh_pwm_chk
// Assertion checker for psh_pwm_top, attached by the bind at the end of this file.
// Assumes: it sees the top's internal counter and settings through the bind.
module psh_pwm_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] m_cnt,
    input logic [W-1:0] act_per,
    input logic [W-1:0] act_duty,
    input logic [W-1:0] act_phase,
    input logic         trig_c,
    input logic         slv_run,
    input logic [W-1:0] slv_cnt,
    input logic [W-1:0] slv_width,
    input logic         trig_o
);

    // The master count never reaches the active period.
    p_cnt_in_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        m_cnt < act_per);

    // A trigger output only follows a nonzero phase match.
    p_trig_on_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> ($past(m_cnt) == $past(act_phase)) && ($past(act_phase) != '0));

    // The slave starts at count 1, one cycle after a trigger.
    p_slave_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slv_run) |-> (slv_cnt == W'(1)) && $past(trig_c));

    // A running slave count stays between 1 and its latched width.
    p_slave_bounds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        slv_run |-> (slv_cnt >= W'(1)) && (slv_cnt <= slv_width));

    // Before the end of a pulse the slave keeps counting, whatever the trigger does.
    p_no_retrigger_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_run && (slv_cnt != slv_width)) |=> slv_run && (slv_cnt == $past(slv_cnt) + 1'b1));

    // Active settings change only where the count is at the period start.
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (m_cnt != '0) |-> $stable(act_per) && $stable(act_duty) && $stable(act_phase));

    // The width latched by a running slave does not change mid-pulse.
    p_width_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_run && $past(slv_run)) |-> $stable(slv_width));

    // The effective period never drops below two.
    p_period_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        act_per >= W'(2));

endmodule

bind psh_pwm_top psh_pwm_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .m_cnt     (m_cnt),
    .act_per   (act_per),
    .act_duty  (act_duty),
    .act_phase (act_phase),
    .trig_c    (trig_c),
    .slv_run   (slv_run),
    .slv_cnt   (slv_cnt),
    .slv_width (slv_width),
    .trig_o    (trig_o)
);

// File: tb/psh_pwm_top_tb_top.sv
// Bench: sweeps phase, width, duty and period on a 5-bit build and measures
// edge delays and high times at the ports.
module psh_pwm_top_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 5;
    localparam int SIG_REF    = 0;
    localparam int SIG_SHIFT  = 1;
    localparam int SIG_TRIG   = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] cfg_period = '0;
    logic [W-1:0] cfg_duty = '0;
    logic [W-1:0] cfg_phase = '0;
    logic [W-1:0] cfg_width = '0;
    logic         ref_pwm_o;
    logic         shift_pwm_o;
    logic         trig_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    psh_pwm_top #(.W(W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_period  (cfg_period),
        .cfg_duty    (cfg_duty),
        .cfg_phase   (cfg_phase),
        .cfg_width   (cfg_width),
        .ref_pwm_o   (ref_pwm_o),
        .shift_pwm_o (shift_pwm_o),
        .trig_o      (trig_o)
    );

    function automatic logic sig(input int which);
        case (which)
            SIG_REF:   return ref_pwm_o;
            SIG_SHIFT: return shift_pwm_o;
            default:   return trig_o;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_cfg(input int p, input int d, input int ph, input int w);
        cfg_period = W'(p);
        cfg_duty   = W'(d);
        cfg_phase  = W'(ph);
        cfg_width  = W'(w);
    endtask

    // Samples until the signal goes from 0 to 1; dt is the sample count, or -1.
    task automatic find_rise(input int which, input int limit, output int dt);
        logic prev;
        prev = sig(which);
        dt = -1;
        for (int i = 1; i <= limit; i++) begin
            step();
            if (!prev && sig(which)) begin
                dt = i;
                break;
            end
            prev = sig(which);
        end
    endtask

    // Counts this sample and the following ones while the signal equals lvl.
    task automatic run_len(input int which, input logic lvl, input int limit, output int n);
        n = 1;
        for (int i = 0; i < limit; i++) begin
            step();
            if (sig(which) == lvl) n++;
            else break;
        end
    endtask

    task automatic count_high(input int which, input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            step();
            if (sig(which)) n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog (all requirements): got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int dt;
        int n;
        set_cfg(12, 5, 4, 3);
        repeat (4) step();
        // R1: quiet outputs during reset
        check("R1 ref in reset", int'(ref_pwm_o), 0);
        check("R1 shift in reset", int'(shift_pwm_o), 0);
        check("R1 trig in reset", int'(trig_o), 0);
        rst_n = 1'b1;
        step();
        check("R1 ref after release", int'(ref_pwm_o), 0);
        check("R1 shift after release", int'(shift_pwm_o), 0);
        check("R1 trig after release", int'(trig_o), 0);

        // R4 R5 R6: every phase value across and past a 12-cycle period
        for (int ph = 0; ph <= 13; ph++) begin
            set_cfg(12, 5, ph, 3);
            repeat (40) step();
            count_high(SIG_TRIG, 12, n);
            check("R4 trigger count", n, (ph >= 1 && ph <= 11) ? 1 : 0);
            find_rise(SIG_REF, 30, dt);
            find_rise(SIG_SHIFT, 24, dt);
            check("R5 shift delay", dt, (ph >= 1 && ph <= 11) ? ph + 1 : -1);
            if (dt > 0) begin
                run_len(SIG_SHIFT, 1'b1, 30, n);
                check("R6 pulse width", n, 3);
            end
        end

        // R6: width sweep including zero
        for (int w = 0; w <= 6; w++) begin
            set_cfg(12, 5, 4, w);
            repeat (40) step();
            find_rise(SIG_REF, 30, dt);
            find_rise(SIG_SHIFT, 24, dt);
            check("R6 rise present", dt, (w == 0) ? -1 : 5);
            if (dt > 0) begin
                run_len(SIG_SHIFT, 1'b1, 30, n);
                check("R6 width sweep", n, w);
            end
        end

        // R2: duty sweep over a 10-cycle period
        for (int d = 0; d <= 11; d++) begin
            set_cfg(10, d, 3, 2);
            repeat (30) step();
            count_high(SIG_REF, 10, n);
            check("R2 ref high count", n, (d < 10) ? d : 10);
        end

        // R3 R9: period sweep, values 0 and 1 clamp to 2
        for (int p = 0; p <= 14; p++) begin
            set_cfg(p, 1, 1, 1);
            repeat (40) step();
            find_rise(SIG_REF, 40, dt);
            find_rise(SIG_REF, 40, dt);
            if (p < 2) check("R9 clamped period", dt, 2);
            else       check("R3 period", dt, p);
        end

        // R7: triggers during a long pulse are ignored
        set_cfg(8, 4, 2, 12);
        repeat (60) step();
        find_rise(SIG_SHIFT, 40, dt);
        run_len(SIG_SHIFT, 1'b1, 40, n);
        check("R7 high time", n, 12);
        run_len(SIG_SHIFT, 1'b0, 40, n);
        check("R7 low time", n, 4);

        // R10: width change during a running pulse
        set_cfg(8, 4, 2, 10);
        repeat (60) step();
        find_rise(SIG_SHIFT, 40, dt);
        cfg_width = W'(2);
        run_len(SIG_SHIFT, 1'b1, 40, n);
        check("R10 running pulse keeps width", n, 10);
        run_len(SIG_SHIFT, 1'b0, 40, n);
        check("R10 gap before next pulse", n, 6);
        run_len(SIG_SHIFT, 1'b1, 40, n);
        check("R10 next pulse new width", n, 2);

        // R8: duty change mid-period applies from the next period
        set_cfg(10, 3, 3, 2);
        repeat (40) step();
        find_rise(SIG_REF, 20, dt);
        cfg_duty = W'(7);
        run_len(SIG_REF, 1'b1, 20, n);
        check("R8 current period keeps duty", n, 3);
        run_len(SIG_REF, 1'b0, 20, n);
        check("R8 current period low time", n, 7);
        run_len(SIG_REF, 1'b1, 20, n);
        check("R8 next period new duty", n, 7);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule